// File: doc/BRIEF.md
# Translation Context Register Bank with Fault Capture

This block holds the software-visible state of a small address-translation unit that serves up to four translation contexts. Each context owns a 64-byte window. The window holds a control word, a set of configuration words that are only stored and read back, a fault status word and a fault address word. A simple synchronous register port reads and writes the windows. The same registers also answer at a second address that differs only in the alias bit. That alias serves as the non-secure view.

The translation engine reports faults on an event port, tagged with a context number. Each context latches the fault kinds, an error level, an error code and the address of the first fault that was not yet acknowledged. Software acknowledges a fault by writing zeros into the status word. One interrupt line combines the pending faults of all contexts whose interrupt enable is set.

Each context also runs a TLB invalidation handshake. A write that sets the flush bit raises a per-context request. The bit reads as 1, and the request stays high, until the engine pulses the matching completion input.

Top module: `xlat_ctx_regs`

## Requirements
- R1: Context c occupies bytes c*0x40 to c*0x40+0x3F. The words at offsets 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x28 and 0x2C are 32-bit storage that reads back exactly what was last written.
- R2: Setting address bit 11 reaches the same registers as the address with that bit clear, for reads and for writes.
- R3: Writing the control word (offset 0x00) with bit 1 set raises `flush_req[c]`, and bit 1 of the control word reads as 1. Both stay set until a cycle in which `inv_done[c]` is high, and then clear. Writing 0 to bit 1 does not cancel a pending flush, and completion pulses for other contexts have no effect.
- R4: In the control word, bit 0 is the translation enable (driven on `xlat_en[c]`), bit 2 is the interrupt enable, and bits 3, 4, 5, 16 and 17 are stored. All other bits read as 0.
- R5: A fault event (`err_valid` with nonzero `err_flags`) for context c sets status bits. The flags map as follows: `err_flags[0]` goes to bit 0 (translation fault), [1] to bit 1 (page fault), [2] to bit 2 (walk abort) and [3] to bit 4 (multiple hit). The level goes to bits 13:12 and the code to bits 10:8. Code 1 means descriptor format, 4 means access permission and 5 means secure access. The flags of later events are ORed in.
- R6: A write to the status word (offset 0x20) keeps only those status bits that are 1 in the written data. Writing 0 clears the word.
- R7: The fault address (offset 0x30, read-only) captures `err_addr` only when the context has no flag set. It is held while any flag is set and reads as 0 while no flag is set. Level and code are also captured only when no flag is set.
- R8: `irq` is the OR over all contexts of (interrupt enable AND any status flag).
- R9: After reset, every register reads 0 and `irq`, `flush_req` and `xlat_en` are 0. Writing 0 to a control word turns that context's translation enable off.
- R10: Reads of unmapped offsets return 0, and writes to them change nothing. Unmapped offsets are any other word offset in a window, any address that is not word-aligned, and any address at 0x100 or above once bit 11 is cleared.
- R11: When a fault event and a status write hit the same context in the same cycle, the write is applied first. The new event is then recorded, and its address is captured if no flag survived the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| err_valid | input | 1 | Fault event strobe from the translation engine |
| err_ctx | input | CTX_W | Context of the fault event |
| err_flags | input | 4 | Fault kinds: translation, page, walk abort, multiple hit |
| err_level | input | 2 | Table level of the fault |
| err_code | input | 3 | Fault code |
| err_addr | input | 32 | Faulting input address |
| inv_done | input | NUM_CTX | Per-context invalidation completion pulse |
| flush_req | output | NUM_CTX | Per-context pending invalidation request |
| xlat_en | output | NUM_CTX | Per-context translation enable |
| irq | output | 1 | Combined fault interrupt |

## Verification
The storage words are swept in every context with a value that encodes the context and the slot. Writes alternate between the plain and the alias address, so that a decode that folds contexts or slots together shows up as a mismatch. All fifteen nonzero flag combinations are injected into each context, with the interrupt enabled in the even contexts only. Each one is followed by a second, different event and then by a clear. This separates the OR accumulation from overwriting, shows that the address is held, and shows how the interrupt is gated by context. Partial clears, an event coinciding with a clear, completion pulses for the wrong context, and writes to unmapped or unaligned addresses each cover one ordering or decode corner.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int unsigned WIN_BITS = 6;
  localparam int unsigned N_STORE  = 8;
  localparam int unsigned STORE_IW = 3;

  localparam logic [31:0] CTRL_KEEP = 32'h0003_003D;
  localparam logic [31:0] STAT_KEEP = 32'h0000_3717;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_EADDR,
    SEL_STORE
  } reg_sel_e;

  // Map a word offset inside a context window to a register kind.
  function automatic reg_sel_e classify(input logic [WIN_BITS-1:0] ofs);
    case (ofs)
      6'h00:   return SEL_CTRL;
      6'h20:   return SEL_STAT;
      6'h30:   return SEL_EADDR;
      6'h08, 6'h0C, 6'h10, 6'h14,
      6'h18, 6'h1C, 6'h28, 6'h2C:
               return SEL_STORE;
      default: return SEL_NONE;
    endcase
  endfunction

  // Storage slot number: 0x08..0x1C give 0..5, 0x28 and 0x2C give 6 and 7.
  function automatic logic [STORE_IW-1:0] store_index(input logic [WIN_BITS-1:0] ofs);
    logic [3:0] word;
    word = ofs[5:2];
    if (ofs[5]) return 3'd6 + {2'b00, ofs[2]};
    return word[2:0] - 3'd2;
  endfunction

  // Assemble the visible status word from its fields.
  function automatic logic [31:0] pack_status(input logic [3:0] flags,
                                               input logic [1:0] level,
                                               input logic [2:0] code);
    return {18'b0, level, 1'b0, code, 3'b0, flags[3], 1'b0, flags[2:0]};
  endfunction

  // Extract the four flag positions from a status-shaped word.
  function automatic logic [3:0] flags_of(input logic [31:0] w);
    return {w[4], w[2], w[1], w[0]};
  endfunction

endpackage

// File: rtl/xlat_addr_decode.sv
module xlat_addr_decode
  import xlat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_CTX   = 4,
  parameter int unsigned CTX_W     = 2,
  parameter int unsigned ALIAS_BIT = 11
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit,
  output logic [CTX_W-1:0]    ctx,
  output reg_sel_e            sel,
  output logic [STORE_IW-1:0] sidx
);

  localparam int unsigned HI_LSB = WIN_BITS + CTX_W;

  logic [ADDR_W-1:0]   folded;
  logic [ADDR_W-1:0]   upper;
  logic [WIN_BITS-1:0] ofs;
  reg_sel_e            sel_raw;

  always_comb begin
    folded            = addr;
    folded[ALIAS_BIT] = 1'b0;
  end

  assign upper   = folded >> HI_LSB;
  assign ofs     = folded[WIN_BITS-1:0];
  assign ctx     = folded[WIN_BITS +: CTX_W];
  assign sel_raw = classify(ofs);
  assign hit     = (upper == '0) && (32'(ctx) < NUM_CTX) && (sel_raw != SEL_NONE);
  assign sel     = hit ? sel_raw : SEL_NONE;
  assign sidx    = store_index(ofs);

endmodule

// File: rtl/xlat_ctx_slot.sv
module xlat_ctx_slot
  import xlat_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ctrl,
  input  logic                wr_stat,
  input  logic                wr_store,
  input  logic [STORE_IW-1:0] sidx,
  input  logic [31:0]         wdata,
  input  logic                evt_hit,
  input  logic [3:0]          evt_flags,
  input  logic [1:0]          evt_level,
  input  logic [2:0]          evt_code,
  input  logic [31:0]         evt_addr,
  input  logic                inv_done,
  output logic [31:0]         ctrl_rd,
  output logic [31:0]         stat_rd,
  output logic [31:0]         eaddr_rd,
  output logic [31:0]         store_rd,
  output logic                xlat_en,
  output logic                flush_pend,
  output logic                irq_src,
  output logic                err_any
);

  logic [31:0] ctrl_q;
  logic        pend_q;
  logic [3:0]  flags_q;
  logic [1:0]  level_q;
  logic [2:0]  code_q;
  logic [31:0] eaddr_q;
  logic [31:0] store_q [N_STORE];

  // Status after an optional software write, before the new event.
  logic [3:0] flags_kept;
  logic [1:0] level_kept;
  logic [2:0] code_kept;
  logic       quiet_kept;
  logic       capture;

  always_comb begin
    flags_kept = flags_q;
    level_kept = level_q;
    code_kept  = code_q;
    if (wr_stat) begin
      flags_kept = flags_q & flags_of(wdata);
      level_kept = level_q & wdata[13:12];
      code_kept  = code_q  & wdata[10:8];
    end
  end

  assign quiet_kept = (flags_kept == 4'b0000);
  assign capture    = evt_hit && quiet_kept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      pend_q  <= 1'b0;
      flags_q <= '0;
      level_q <= '0;
      code_q  <= '0;
      eaddr_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata & CTRL_KEEP;
      if (wr_ctrl && wdata[1]) pend_q <= 1'b1;
      else if (inv_done)       pend_q <= 1'b0;
      flags_q <= flags_kept | (evt_hit ? evt_flags : 4'b0000);
      level_q <= capture ? evt_level : level_kept;
      code_q  <= capture ? evt_code  : code_kept;
      if (capture) eaddr_q <= evt_addr;
    end
  end

  for (genvar k = 0; k < N_STORE; k++) begin : g_store
    always_ff @(posedge clk) begin
      if (!rst_n)                                 store_q[k] <= '0;
      else if (wr_store && sidx == STORE_IW'(k))  store_q[k] <= wdata;
    end
  end

  assign ctrl_rd    = ctrl_q | {30'b0, pend_q, 1'b0};
  assign stat_rd    = pack_status(flags_q, level_q, code_q);
  assign err_any    = (flags_q != 4'b0000);
  assign eaddr_rd   = err_any ? eaddr_q : 32'h0;
  assign store_rd   = store_q[sidx];
  assign xlat_en    = ctrl_q[0];
  assign flush_pend = pend_q;
  assign irq_src    = ctrl_q[2] && err_any;

endmodule

// File: rtl/xlat_ctx_regs.sv
module xlat_ctx_regs
  import xlat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_CTX   = 4,
  parameter int unsigned ALIAS_BIT = 11,
  localparam int unsigned CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               err_valid,
  input  logic [CTX_W-1:0]   err_ctx,
  input  logic [3:0]         err_flags,
  input  logic [1:0]         err_level,
  input  logic [2:0]         err_code,
  input  logic [31:0]        err_addr,
  input  logic [NUM_CTX-1:0] inv_done,
  output logic [NUM_CTX-1:0] flush_req,
  output logic [NUM_CTX-1:0] xlat_en,
  output logic               irq
);

  logic                dec_hit;
  logic [CTX_W-1:0]    dec_ctx;
  reg_sel_e            dec_sel;
  logic [STORE_IW-1:0] dec_sidx;

  xlat_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .ALIAS_BIT(ALIAS_BIT)
  ) u_dec (
    .addr(bus_addr), .hit(dec_hit), .ctx(dec_ctx), .sel(dec_sel), .sidx(dec_sidx)
  );

  // Named per-context events, used by the slots and by the checker.
  logic [NUM_CTX-1:0] wr_ctx;
  logic [NUM_CTX-1:0] flush_set;
  logic [NUM_CTX-1:0] stat_clr0;
  logic [NUM_CTX-1:0] ctrl_zero;
  logic [NUM_CTX-1:0] evt_sel;
  logic [NUM_CTX-1:0] err_any;
  logic [NUM_CTX-1:0] irq_src;

  logic [31:0] ctrl_rd  [NUM_CTX];
  logic [31:0] stat_rd  [NUM_CTX];
  logic [31:0] eaddr_rd [NUM_CTX];
  logic [31:0] store_rd [NUM_CTX];

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    assign wr_ctx[c]    = bus_wr && dec_hit && (dec_ctx == CTX_W'(c));
    assign flush_set[c] = wr_ctx[c] && (dec_sel == SEL_CTRL) && bus_wdata[1];
    assign ctrl_zero[c] = wr_ctx[c] && (dec_sel == SEL_CTRL) && (bus_wdata == 32'h0);
    assign stat_clr0[c] = wr_ctx[c] && (dec_sel == SEL_STAT) && (bus_wdata == 32'h0);
    assign evt_sel[c]   = err_valid && (err_ctx == CTX_W'(c)) && (err_flags != 4'b0000);

    xlat_ctx_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (wr_ctx[c] && dec_sel == SEL_CTRL),
      .wr_stat   (wr_ctx[c] && dec_sel == SEL_STAT),
      .wr_store  (wr_ctx[c] && dec_sel == SEL_STORE),
      .sidx      (dec_sidx),
      .wdata     (bus_wdata),
      .evt_hit   (evt_sel[c]),
      .evt_flags (err_flags),
      .evt_level (err_level),
      .evt_code  (err_code),
      .evt_addr  (err_addr),
      .inv_done  (inv_done[c]),
      .ctrl_rd   (ctrl_rd[c]),
      .stat_rd   (stat_rd[c]),
      .eaddr_rd  (eaddr_rd[c]),
      .store_rd  (store_rd[c]),
      .xlat_en   (xlat_en[c]),
      .flush_pend(flush_req[c]),
      .irq_src   (irq_src[c]),
      .err_any   (err_any[c])
    );
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (dec_hit) begin
      case (dec_sel)
        SEL_CTRL:  bus_rdata = ctrl_rd[dec_ctx];
        SEL_STAT:  bus_rdata = stat_rd[dec_ctx];
        SEL_EADDR: bus_rdata = eaddr_rd[dec_ctx];
        SEL_STORE: bus_rdata = store_rd[dec_ctx];
        default:   bus_rdata = 32'h0;
      endcase
    end
  end

  assign irq = |irq_src;

endmodule

// File: rtl/xlat_ctx_regs_chk.sv
module xlat_ctx_regs_chk #(
  parameter int unsigned NUM_CTX = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic               err_valid,
  input logic               irq,
  input logic [NUM_CTX-1:0] flush_req,
  input logic [NUM_CTX-1:0] inv_done,
  input logic [NUM_CTX-1:0] flush_set,
  input logic [NUM_CTX-1:0] stat_clr0,
  input logic [NUM_CTX-1:0] ctrl_zero,
  input logic [NUM_CTX-1:0] evt_sel,
  input logic [NUM_CTX-1:0] err_any,
  input logic [NUM_CTX-1:0] xlat_en
);

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_chk
    AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req[c] && !inv_done[c] |=> flush_req[c]);                         // R3
    AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req[c] && inv_done[c] && !flush_set[c] |=> !flush_req[c]);        // R3
    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flush_req[c]) |-> $past(flush_set[c]));                           // R3
    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      evt_sel[c] |=> err_any[c]);                                             // R5
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      stat_clr0[c] && !evt_sel[c] |=> !err_any[c]);                           // R6
    AST_CTRL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_zero[c] |=> !xlat_en[c]);                                          // R9
  end

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(err_valid || bus_wr));                               // R8

endmodule

bind xlat_ctx_regs xlat_ctx_regs_chk #(.NUM_CTX(NUM_CTX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .err_valid (err_valid),
  .irq       (irq),
  .flush_req (flush_req),
  .inv_done  (inv_done),
  .flush_set (flush_set),
  .stat_clr0 (stat_clr0),
  .ctrl_zero (ctrl_zero),
  .evt_sel   (evt_sel),
  .err_any   (err_any),
  .xlat_en   (xlat_en)
);

// File: tb/test_xlat_ctx_regs.sv
module test_xlat_ctx_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        err_valid = 1'b0;
  logic [1:0]  err_ctx = '0;
  logic [3:0]  err_flags = '0;
  logic [1:0]  err_level = '0;
  logic [2:0]  err_code = '0;
  logic [31:0] err_addr = '0;
  logic [3:0]  inv_done = '0;
  logic [3:0]  flush_req;
  logic [3:0]  xlat_en;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xlat_ctx_regs i_xlat_ctx_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_valid(err_valid),
    .err_ctx(err_ctx), .err_flags(err_flags), .err_level(err_level),
    .err_code(err_code), .err_addr(err_addr), .inv_done(inv_done),
    .flush_req(flush_req), .xlat_en(xlat_en), .irq(irq)
  );

  function automatic logic [31:0] exp_stat(input logic [3:0] f, input logic [1:0] l,
                                           input logic [2:0] cd);
    return (32'(f[0])) | (32'(f[1]) << 1) | (32'(f[2]) << 2) | (32'(f[3]) << 4)
         | (32'(cd) << 8) | (32'(l) << 12);
  endfunction

  function automatic logic [11:0] slot_ofs(input int k);
    return (k < 6) ? 12'(8 + 4 * k) : 12'(8'h28 + 4 * (k - 6));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic evt(input int c, input logic [3:0] f, input logic [1:0] l,
                     input logic [2:0] cd, input logic [31:0] a);
    @(negedge clk);
    err_valid = 1'b1; err_ctx = 2'(c); err_flags = f;
    err_level = l; err_code = cd; err_addr = a;
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  task automatic pulse_done(input int c);
    @(negedge clk);
    inv_done[c] = 1'b1;
    @(negedge clk);
    inv_done = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: reset state
    check("R9 irq", 32'(irq), 0);
    check("R9 flush_req", 32'(flush_req), 0);
    check("R9 xlat_en", 32'(xlat_en), 0);
    for (int c = 0; c < 4; c++) begin
      rd(12'(c * 64) + 12'h00, 0, "R9 ctrl reset");
      rd(12'(c * 64) + 12'h20, 0, "R9 status reset");
      rd(12'(c * 64) + 12'h30, 0, "R9 eaddr reset");
    end

    // R1/R2: storage sweep, writes alternate between plain and alias
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 8; k++)
        wr(12'(c * 64) + slot_ofs(k) + ((k % 2 == 1) ? 12'h800 : 12'h000),
           32'hA500_0000 ^ (32'(c) << 12) ^ (32'(k) << 4) ^ 32'(c + k));
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 8; k++) begin
        rd(12'(c * 64) + slot_ofs(k),
           32'hA500_0000 ^ (32'(c) << 12) ^ (32'(k) << 4) ^ 32'(c + k), "R1 storage");
        rd(12'(c * 64) + slot_ofs(k) + 12'h800,
           32'hA500_0000 ^ (32'(c) << 12) ^ (32'(k) << 4) ^ 32'(c + k), "R2 alias read");
      end

    // R4/R9: control bit set, then disable by writing zero
    for (int c = 0; c < 4; c++) begin
      wr(12'(c * 64), 32'hFFFF_FFFD);
      rd(12'(c * 64), 32'h0003_003D, "R4 ctrl mask");
      check("R4 xlat_en on", 32'(xlat_en[c]), 1);
      wr(12'(c * 64), 32'h0);
      rd(12'(c * 64), 32'h0, "R9 ctrl zero");
      check("R9 xlat_en off", 32'(xlat_en[c]), 0);
    end

    // R3: flush handshake
    wr(12'h080, 32'h3);
    rd(12'h080, 32'h3, "R3 flush bit reads 1");
    check("R3 flush_req raised", 32'(flush_req), 32'h4);
    repeat (5) @(negedge clk);
    pulse_done(1);
    #1;
    check("R3 flush held, other done", 32'(flush_req), 32'h4);
    wr(12'h080, 32'h0);
    rd(12'h080, 32'h2, "R3 zero write keeps pending");
    pulse_done(2);
    #1;
    check("R3 flush_req cleared", 32'(flush_req), 0);
    rd(12'h080, 32'h0, "R3 flush bit cleared");

    // R5/R6/R7/R8: every flag combination in every context
    for (int c = 0; c < 4; c++) begin
      wr(12'(c * 64), (c % 2 == 0) ? 32'h4 : 32'h0);
      for (int f = 1; f < 16; f++) begin
        logic [3:0]  g;
        logic [31:0] a1;
        g  = (4'(f) == 4'hF) ? 4'h1 : ~4'(f);
        a1 = 32'h1000_0000 + (32'(c) << 16) + 32'(f);
        evt(c, 4'(f), 2'(f), 3'(f * 3), a1);
        rd(12'(c * 64) + 12'h20, exp_stat(4'(f), 2'(f), 3'(f * 3)), "R5 status latch");
        rd(12'(c * 64) + 12'h30, a1, "R7 address capture");
        check("R8 irq gated", 32'(irq), (c % 2 == 0) ? 1 : 0);
        evt(c, g, 2'(f + 1), 3'(f + 1), 32'hDEAD_0000 + 32'(f));
        rd(12'(c * 64) + 12'h20, exp_stat(4'(f) | g, 2'(f), 3'(f * 3)), "R5 flags OR");
        rd(12'(c * 64) + 12'h30, a1, "R7 address held");
        wr(12'(c * 64) + 12'h20, 32'h0);
        rd(12'(c * 64) + 12'h20, 32'h0, "R6 zero clears");
        rd(12'(c * 64) + 12'h30, 32'h0, "R7 address reads zero");
        check("R8 irq after clear", 32'(irq), 0);
      end
      wr(12'(c * 64), 32'h0);
    end

    // R6: partial clear keeps only ones in the data
    evt(1, 4'hF, 2'd3, 3'd5, 32'h0000_BEEF);
    wr(12'h060, 32'h0000_1005);
    rd(12'h060, 32'h0000_1005, "R6 partial clear");
    rd(12'h070, 32'h0000_BEEF, "R7 held after partial clear");
    wr(12'h060, 32'h0);

    // R11: clear and event in the same cycle
    evt(3, 4'h1, 2'd1, 3'd1, 32'h0000_AAAA);
    @(negedge clk);
    bus_addr = 12'h0E0; bus_wdata = 32'h0; bus_wr = 1'b1;
    err_valid = 1'b1; err_ctx = 2'd3; err_flags = 4'h2;
    err_level = 2'd2; err_code = 3'd4; err_addr = 32'h0000_BBBB;
    @(negedge clk);
    bus_wr = 1'b0; err_valid = 1'b0;
    rd(12'h0E0, exp_stat(4'h2, 2'd2, 3'd4), "R11 event kept");
    rd(12'h0F0, 32'h0000_BBBB, "R11 new address");
    wr(12'h0E0, 32'h0);

    // R10: unmapped reads and ignored writes
    wr(12'h000, 32'h5);
    wr(12'h024, 32'hFFFF_FFFF);
    wr(12'h034, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h001, 32'hFFFF_FFFF);
    wr(12'h900, 32'hFFFF_FFFF);
    rd(12'h024, 0, "R10 read hole");
    rd(12'h034, 0, "R10 read hole 2");
    rd(12'h100, 0, "R10 read past windows");
    rd(12'h001, 0, "R10 read unaligned");
    rd(12'h000, 32'h5, "R10 ctrl untouched");
    rd(12'h008, 32'hA500_0000, "R10 storage untouched");
    rd(12'h020, 0, "R10 status untouched");
    check("R10 irq quiet", 32'(irq), 0);

    // R8: OR across contexts
    wr(12'h000, 32'h1);
    wr(12'h040, 32'h4);
    evt(0, 4'h4, 2'd0, 3'd1, 32'h10);
    #1;
    check("R8 irq masked ctx0", 32'(irq), 0);
    evt(1, 4'h8, 2'd0, 3'd1, 32'h20);
    #1;
    check("R8 irq from ctx1", 32'(irq), 1);
    wr(12'h060, 32'h0);
    #1;
    check("R8 irq ctx1 cleared", 32'(irq), 0);
    wr(12'h000, 32'h4);
    #1;
    check("R8 irq by enabling ctx0", 32'(irq), 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule